// File: doc/BRIEF.md
# DC-Balanced Video/Control Word Framer

The framer turns a stream of parallel pixel beats into 20-bit line words for a downstream shift register, which sends bit 0 first. Each beat carries a data-enable flag, 18 video bits and 9 control bits. While enable is high the beat becomes a video word. While enable is low it becomes a control word. Where the stream moves between the two phases, a fixed transition word takes the place of the control slot next to the boundary.

Two beats of look-ahead let the framer see an enable rise before the control data next to it is encoded. Control inputs are not sampled in the slots near a boundary; those slots carry the last sampled control value again. Every video and control word goes out either in true form or bit-inverted, whichever pulls a running disparity counter toward zero. The inversion is marked in the word itself.

Both edges of the block are valid/ready streams. An input beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the output word and tag hold still, and no input is accepted. Idle cycles (`in_valid` low) change no state.

Top module: `vfrm_framer`

## Requirements
- R1: A control word has bit 0 = 0 in true form. Control input i (i = 0..4) fills bits 3i+1..3i+3. Control inputs 5..8 fill bits 16..19 in that order. The inverted form is the bitwise complement of the whole true word, so bit 0 = 1 marks inversion. Tag 0 marks a control word.
- R2: A video word in true form has bits 1:0 = 2'b01 and video bit j in bit j+2. The inverted form is the complement of the whole word (bits 1:0 = 2'b10). Tag 1 marks a video word.
- R3: Let D be the running disparity, the sum of (ones - zeros) over all words sent so far. D starts at 0. Let d be the true-form disparity of a video or control word. The word is inverted exactly when D and d are both nonzero and have the same sign. As a result, |D| never exceeds 20.
- R4: Video bits have no effect on control words, and control bits have no effect on video words.
- R5: The first control slot after a video word carries 20'h3C3C3 with tag 2. The control slot directly before a video word carries 20'hC3C3C with tag 3. When a control gap is a single slot, the 20'hC3C3C word takes it. Both constants have ten ones, and neither matches the form of any video or control word.
- R6: The second control slot after a video word, and the control slot two places before a video word, are not sampled. Each carries the last sampled control value, which is 0 after reset. Only the other control slots sample `in_ctl`.
- R7: Every accepted beat produces exactly one word, and words come out in acceptance order. The word for beat n becomes valid right after the beat that accepts beat n+2.
- R8: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, `out_word` and `out_tag` do not change.
- R9: After reset, `out_valid` is 0 and the stream counts as deep in the control phase, so the first control slots are sampled and sent uninverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be accepted |
| in_de | input | 1 | 1 = video beat, 0 = control beat |
| in_vid | input | 18 | Video bits |
| in_ctl | input | 9 | Control bits |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_word | output | 20 | Line word, bit 0 sent first |
| out_tag | output | 2 | 0 control, 1 video, 2 video-to-control, 3 control-to-video |

## Verification
Long video runs with all-ones, all-zeros and mixed patterns separate a correct inversion choice from a stuck polarity, because all-ones words must alternate polarity. Control gaps of one to five slots between video bursts separate the boundary priority and the blanked slots from the sampled ones. Control values change on every beat so that a held slot can be told apart from a fresh sample. Beats with idle gaps and a stalled output show that neither pauses nor back-pressure move the look-ahead or the disparity.

// File: rtl/vfrm_pkg.sv
package vfrm_pkg;
  localparam int VID_W    = 18;
  localparam int CTL_W    = 9;
  localparam int REP_N    = 5;                 // control inputs sent three times
  localparam int REP_K    = 3;
  localparam int EN_W     = 2;
  localparam int WORD_W   = EN_W + VID_W;
  localparam int SGL_BASE = 1 + REP_N * REP_K;  // first single-copy control bit
  localparam int DISP_W   = $clog2(WORD_W) + 2;
  localparam int LOOK     = 2;                 // beats of look-ahead
  localparam int CNT_W    = $clog2(LOOK + 1);

  localparam logic [WORD_W-1:0] TVC_WORD = 20'h3C3C3;
  localparam logic [WORD_W-1:0] TCV_WORD = 20'hC3C3C;

  typedef enum logic [1:0] {
    TAG_CTL = 2'd0, TAG_VID = 2'd1, TAG_TVC = 2'd2, TAG_TCV = 2'd3
  } tag_e;

  typedef enum logic [2:0] {
    K_VID, K_SAMP, K_HELD, K_TVC, K_TCV
  } kind_e;

  typedef struct packed {
    logic             de;
    logic [VID_W-1:0] vid;
    logic [CTL_W-1:0] ctl;
  } item_t;
endpackage

// File: rtl/vfrm_lookahead.sv
module vfrm_lookahead
  import vfrm_pkg::*;
#(
  parameter int DEPTH = LOOK
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  item_t in_item,
  output item_t cur_item,
  output logic  cur_valid,
  output logic  nxt_de
);
  item_t            stg [DEPTH];
  logic [DEPTH-1:0] vld;

  // beats shift one stage per accepted input; idle cycles leave them still
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
      vld <= '0;
    end else if (adv) begin
      stg[0] <= in_item;
      vld[0] <= 1'b1;
      for (int i = 1; i < DEPTH; i++) begin
        stg[i] <= stg[i-1];
        vld[i] <= vld[i-1];
      end
    end
  end

  assign cur_item  = stg[DEPTH-1];
  assign cur_valid = vld[DEPTH-1];
  assign nxt_de    = stg[DEPTH-2].de;
endmodule

// File: rtl/vfrm_sequencer.sv
module vfrm_sequencer
  import vfrm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emit,
  input  logic             cur_de,
  input  logic             nxt_de,
  input  logic             new_de,
  input  logic [CTL_W-1:0] cur_ctl,
  output kind_e            kind,
  output logic [CTL_W-1:0] ctl_pay
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LOOK);

  logic [CNT_W-1:0] since_vid;  // control slots sent since the last video word
  logic [CTL_W-1:0] held;

  // the slot just before video outranks the slot just after video
  always_comb begin
    if (cur_de)                            kind = K_VID;
    else if (nxt_de)                       kind = K_TCV;
    else if (since_vid == '0)              kind = K_TVC;
    else if (new_de || since_vid < CNT_SAT) kind = K_HELD;
    else                                   kind = K_SAMP;
  end

  assign ctl_pay = (kind == K_SAMP) ? cur_ctl : held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_vid <= CNT_SAT;
      held      <= '0;
    end else if (emit) begin
      if (cur_de)                since_vid <= '0;
      else if (since_vid != CNT_SAT) since_vid <= since_vid + 1'b1;
      if (kind == K_SAMP) held <= cur_ctl;
    end
  end

  // R6: a slot that is not sampled must leave the held value untouched
  a_r6_held_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && kind != K_SAMP) |=> held == $past(held));
endmodule

// File: rtl/vfrm_balance.sv
module vfrm_balance
  import vfrm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  kind_e             kind,
  input  logic [VID_W-1:0]  vid,
  input  logic [CTL_W-1:0]  ctl_pay,
  output logic [WORD_W-1:0] word,
  output tag_e              tag
);
  localparam logic signed [DISP_W-1:0] DMAX = DISP_W'(WORD_W);

  logic [WORD_W-1:0]        plain;
  logic signed [DISP_W-1:0] rd, dt, dsel;
  logic                     bal, inv;
  int                       ones;

  // true-form layout for video and control
  always_comb begin
    plain = '0;
    if (kind == K_VID) begin
      plain[EN_W-1:0]      = 2'b01;
      plain[WORD_W-1:EN_W] = vid;
    end else begin
      for (int r = 0; r < REP_N; r++)
        for (int k = 0; k < REP_K; k++)
          plain[1 + r*REP_K + k] = ctl_pay[r];
      for (int s = 0; s < CTL_W - REP_N; s++)
        plain[SGL_BASE + s] = ctl_pay[REP_N + s];
    end
  end

  always_comb begin
    ones = 0;
    for (int i = 0; i < WORD_W; i++) ones = ones + int'(plain[i]);
  end

  assign dt   = DISP_W'(2*ones - WORD_W);
  assign bal  = (kind == K_VID) || (kind == K_SAMP) || (kind == K_HELD);
  assign inv  = bal && (rd != '0) && (dt != '0) && (rd[DISP_W-1] == dt[DISP_W-1]);
  assign dsel = !bal ? '0 : (inv ? -dt : dt);

  always_comb begin
    unique case (kind)
      K_TVC:   begin word = TVC_WORD; tag = TAG_TVC; end
      K_TCV:   begin word = TCV_WORD; tag = TAG_TCV; end
      K_VID:   begin word = inv ? ~plain : plain; tag = TAG_VID; end
      default: begin word = inv ? ~plain : plain; tag = TAG_CTL; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd <= '0;
    else if (emit) rd <= rd + dsel;
  end

  a_r3_disp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rd <= DMAX) && (rd >= -DMAX));
endmodule

// File: rtl/vfrm_framer.sv
module vfrm_framer
  import vfrm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_de,
  input  logic [VID_W-1:0]  in_vid,
  input  logic [CTL_W-1:0]  in_ctl,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic [1:0]        out_tag
);
  item_t             in_item, cur_item;
  logic              adv, emit, cur_valid, nxt_de;
  kind_e             kind;
  logic [CTL_W-1:0]  ctl_pay;
  logic [WORD_W-1:0] word;
  tag_e              tag, last_tag;

  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready;
  assign emit     = adv && cur_valid;
  assign in_item  = '{de: in_de, vid: in_vid, ctl: in_ctl};

  vfrm_lookahead u_look (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_item(in_item),
    .cur_item(cur_item), .cur_valid(cur_valid), .nxt_de(nxt_de)
  );

  vfrm_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .emit(emit), .cur_de(cur_item.de),
    .nxt_de(nxt_de), .new_de(in_de), .cur_ctl(cur_item.ctl),
    .kind(kind), .ctl_pay(ctl_pay)
  );

  vfrm_balance u_bal (
    .clk(clk), .rst_n(rst_n), .emit(emit), .kind(kind),
    .vid(cur_item.vid), .ctl_pay(ctl_pay), .word(word), .tag(tag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_tag   <= TAG_CTL;
      last_tag  <= TAG_TCV;
    end else if (adv) begin
      out_valid <= cur_valid;
      if (cur_valid) begin
        out_word <= word;
        out_tag  <= tag;
        last_tag <= tag;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_word) && $stable(out_tag));

  a_r7_valid_from_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  a_r5_cv_before_video: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && tag == TAG_VID) |-> (last_tag == TAG_VID || last_tag == TAG_TCV));

  a_r5_vc_after_video: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && last_tag == TAG_VID && tag != TAG_VID) |-> (tag == TAG_TVC || tag == TAG_TCV));
endmodule

// File: tb/tb_vfrm_framer.sv
module tb_vfrm_framer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid, in_ready, in_de, out_valid, out_ready;
  logic [17:0] in_vid;
  logic [8:0]  in_ctl;
  logic [19:0] out_word;
  logic [1:0]  out_tag;

  vfrm_framer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_de(in_de), .in_vid(in_vid), .in_ctl(in_ctl), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .out_tag(out_tag)
  );

  int n_chk = 0, n_err = 0;
  bit          sd [4096];
  logic [17:0] sv [4096];
  logic [8:0]  sc [4096];
  logic [19:0] rword [4096];
  logic [1:0]  rtag [4096];
  int nsent = 0, nrecv = 0;

  // reference model state
  int m_cnt = 2, m_rd = 0, o_rd = 0;
  logic [8:0] m_held = '0;

  function automatic int disp(input logic [19:0] w);
    int n = 0;
    for (int i = 0; i < 20; i++) n += int'(w[i]);
    return 2*n - 20;
  endfunction

  function automatic logic [19:0] ctl_word(input logic [8:0] c);
    logic [19:0] w = '0;
    for (int b = 1; b < 16; b++) w[b] = c[(b-1)/3];
    for (int b = 16; b < 20; b++) w[b] = c[b-11];
    return w;
  endfunction

  function automatic logic [8:0] dec_ctl(input logic [19:0] w0);
    logic [19:0] w = w0[0] ? ~w0 : w0;
    logic [8:0]  c;
    for (int i = 0; i < 5; i++) c[i] = w[1 + 3*i];
    for (int j = 0; j < 4; j++) c[5+j] = w[16+j];
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // output monitor: compares every transferred word with the model
  bit          mc, mn1, mn2;
  int          mk, mkind;
  logic [19:0] mtw, mew;
  logic [1:0]  metag;
  string       mrq;
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      mk = nrecv;
      if (mk + 2 >= nsent)
        check(1'b0, "R7", "word before its look-ahead beats", 20'(mk), 20'(nsent));
      mc = sd[mk]; mn1 = sd[mk+1]; mn2 = sd[mk+2];
      if (mc) mkind = 0;
      else if (mn1) mkind = 4;
      else if (m_cnt == 0) mkind = 3;
      else if (mn2 || m_cnt == 1) mkind = 2;
      else mkind = 1;
      mtw = '0; mew = '0;
      case (mkind)
        0: begin mtw = {sv[mk], 2'b01}; metag = 2'd1; mrq = "R2"; end
        1: begin mtw = ctl_word(sc[mk]); metag = 2'd0; mrq = "R1"; end
        2: begin mtw = ctl_word(m_held); metag = 2'd0; mrq = "R6"; end
        3: begin mew = 20'h3C3C3; metag = 2'd2; mrq = "R5"; end
        default: begin mew = 20'hC3C3C; metag = 2'd3; mrq = "R5"; end
      endcase
      if (mkind <= 2) begin
        if (m_rd != 0 && disp(mtw) != 0 && ((m_rd < 0) == (disp(mtw) < 0))) mew = ~mtw;
        else mew = mtw;
        m_rd += disp(mew);
      end
      if (mc) m_cnt = 0;
      else if (m_cnt < 2) m_cnt++;
      if (mkind == 1) m_held = sc[mk];
      check(out_word == mew, mrq, "word", out_word, mew);
      check(out_tag == metag, mrq, "tag", 20'(out_tag), 20'(metag));
      o_rd += disp(out_word);
      check(o_rd <= 20 && o_rd >= -20, "R3", "running disparity bound", 20'(o_rd), 20'd20);
      rword[mk] = out_word;
      rtag[mk]  = out_tag;
      nrecv++;
    end
  end

  task automatic push(input bit de, input logic [17:0] v, input logic [8:0] c);
    in_de = de; in_vid = v; in_ctl = c; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    sd[nsent] = de; sv[nsent] = v; sc[nsent] = c; nsent++;
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic flush();
    push(1'b0, 18'h15555, 9'h0AA);
    push(1'b0, 18'h2AAAA, 9'h155);
    @(negedge clk); @(posedge clk); #2;
  endtask

  task automatic expect_tag(input int idx, input logic [1:0] t, input string req);
    check(rtag[idx] == t, req, $sformatf("tag of beat %0d", idx), 20'(rtag[idx]), 20'(t));
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R9", "out_valid after reset", 20'(out_valid), 20'd0);
    check(in_ready == 1'b1, "R8", "in_ready with empty output", 20'(in_ready), 20'd1);
  endtask

  task automatic t_latency();
    push(1'b0, 18'h3FFFF, 9'h1A5);
    check(out_valid == 1'b0, "R7", "valid after one beat", 20'(out_valid), 20'd0);
    push(1'b0, 18'h00000, 9'h0F3);
    check(out_valid == 1'b0, "R7", "valid after two beats", 20'(out_valid), 20'd0);
    push(1'b0, 18'h12345, 9'h155);
    check(out_valid == 1'b1, "R7", "valid after three beats", 20'(out_valid), 20'd1);
    check(out_tag == 2'd0, "R9", "first word is plain control", 20'(out_tag), 20'd0);
    check(out_word == ctl_word(9'h1A5), "R9", "first word uninverted", out_word, ctl_word(9'h1A5));
  endtask

  task automatic t_run();
    int b = nsent;
    logic [17:0] pats [8] = '{18'h3FFFF, 18'h00000, 18'h2AAAA, 18'h15555,
                              18'h3F000, 18'h00FFF, 18'h1C71C, 18'h0BEEF};
    for (int i = 0; i < 4; i++) push(1'b0, 18'(i * 7), 9'(i * 37 + 3));
    for (int i = 0; i < 8; i++) push(1'b1, pats[i], 9'(i * 11));
    for (int i = 0; i < 6; i++) push(1'b0, 18'(i), 9'(i * 53 + 9));
    flush();
    expect_tag(b + 3, 2'd3, "R5");
    expect_tag(b + 4, 2'd1, "R2");
    expect_tag(b + 11, 2'd1, "R2");
    expect_tag(b + 12, 2'd2, "R5");
    expect_tag(b + 13, 2'd0, "R6");
  endtask

  task automatic t_gaps();
    int b = nsent;
    // V V | C | V V | C C | V V | C C C | V V | C C C C C | V
    bit pat [20] = '{1,1,0,1,1,0,0,1,1,0,0,0,1,1,0,0,0,0,0,1};
    for (int i = 0; i < 20; i++) push(pat[i], 18'(i * 4097), 9'(i * 29 + 1));
    flush();
    expect_tag(b + 2, 2'd3, "R5");
    expect_tag(b + 5, 2'd2, "R5");
    expect_tag(b + 6, 2'd3, "R5");
    expect_tag(b + 9, 2'd2, "R5");
    expect_tag(b + 10, 2'd0, "R6");
    expect_tag(b + 11, 2'd3, "R5");
    expect_tag(b + 14, 2'd2, "R5");
    expect_tag(b + 16, 2'd0, "R1");
    check(dec_ctl(rword[b+16]) == sc[b+16], "R6", "middle slot sampled",
          20'(dec_ctl(rword[b+16])), 20'(sc[b+16]));
    check(dec_ctl(rword[b+17]) == sc[b+16], "R6", "slot two before video holds",
          20'(dec_ctl(rword[b+17])), 20'(sc[b+16]));
  endtask

  task automatic t_ignore();
    int b = nsent;
    logic [19:0] w;
    logic [17:0] v;
    for (int i = 0; i < 5; i++) push(1'b0, 18'h3FFFF - 18'(i), 9'(i * 71 + 5));
    push(1'b1, 18'h2C3A5, 9'h1FF);
    for (int i = 0; i < 4; i++) push(1'b0, 18'h3FFFF, 9'(i * 13));
    flush();
    check(dec_ctl(rword[b+2]) == sc[b+2], "R4", "control word ignores video bits",
          20'(dec_ctl(rword[b+2])), 20'(sc[b+2]));
    w = rword[b+5];
    v = (w[1:0] == 2'b01) ? w[19:2] : ~w[19:2];
    check(v == sv[b+5], "R4", "video word ignores control bits", 20'(v), 20'(sv[b+5]));
    check(w[1:0] == 2'b01 || w[1:0] == 2'b10, "R2", "video overhead bits",
          20'(w[1:0]), 20'd1);
  endtask

  task automatic t_disp();
    int b = nsent;
    for (int i = 0; i < 10; i++) push(1'b1, 18'h3FFFF, 9'h000);
    for (int i = 0; i < 6; i++) push(1'b0, 18'h0, 9'h1FF);
    for (int i = 0; i < 10; i++) push(1'b1, 18'h00000, 9'h000);
    flush();
    for (int i = b + 2; i < b + 9; i++)
      check(rword[i][0] != rword[i+1][0], "R3", $sformatf("polarity alternates at %0d", i),
            20'(rword[i+1][0]), 20'(!rword[i][0]));
  endtask

  task automatic t_backpressure();
    logic [19:0] w0;
    logic [1:0]  t0;
    push(1'b0, 18'h1, 9'h0C3);
    push(1'b0, 18'h2, 9'h13C);
    out_ready = 1'b0;
    @(negedge clk);
    w0 = out_word; t0 = out_tag;
    check(out_valid == 1'b1, "R8", "word waiting under stall", 20'(out_valid), 20'd1);
    check(in_ready == 1'b0, "R8", "in_ready low under stall", 20'(in_ready), 20'd0);
    repeat (3) @(negedge clk);
    check(out_word == w0, "R8", "word stable under stall", out_word, w0);
    check(out_tag == t0, "R8", "tag stable under stall", 20'(out_tag), 20'(t0));
    @(posedge clk); #2;
    out_ready = 1'b1;
    flush();
  endtask

  task automatic t_idle();
    for (int i = 0; i < 24; i++) begin
      push(1'($urandom_range(0, 2) == 0 ? 0 : 1) ^ 1'(i % 5 == 0),
           18'($urandom), 9'($urandom));
      repeat ($urandom_range(0, 3)) @(posedge clk);
      #2;
    end
    flush();
    check(nrecv == nsent - 2, "R7", "one word per beat", 20'(nrecv), 20'(nsent - 2));
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_de = 1'b0; in_vid = '0; in_ctl = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_latency();
    t_run();
    t_gaps();
    t_ignore();
    t_disp();
    t_backpressure();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R7 watchdog expired: actual %0d words expected %0d", nrecv, nsent);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule